// File: doc/BRIEF.md
# Serial NOR Flash Slave Emulator

This block is a synthesizable SPI slave (mode 0, most significant bit first) that answers like a small serial NOR flash, so that SPI flash masters can be exercised against a realistic target. It decodes single-byte opcodes and holds a status byte with busy and write-enable flags, protection bits and a protection-lock bit. Its data lives in an internal byte array whose size is a parameter. Flash addresses above that size wrap onto it.

All SPI pins are sampled by the fast system clock through two-stage synchronisers. The slave samples MOSI on rising SCK and updates MISO after falling SCK, so SCK must stay low and high for at least four system clocks each. Program and erase orders are only accepted once the chip select has been released. They then run as a busy period of parameterised length. During that period a walker applies the change to the array one byte per cycle. A program only clears bits. An erase fills its range with 0xFF. The signature reply follows a CHIP_MIB parameter that names the size of the emulated device.

Top module: `nor_flash_emu`

## Requirements
- R1: After reset the status byte reads 0x00 (bit 0 busy, bit 1 write-enable latch, bits 4:2 protection, bit 7 protection lock) and MISO is low.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) when chip select rises; opcode 0x04 clears it.
- R3: Page program, sector erase, bulk erase and status write are ignored when the write-enable latch is clear: memory and status stay unchanged.
- R4: Page program (0x02, three address bytes MSB first, then data) stores the bitwise AND of the old byte and the new byte.
- R5: Program data that runs past the end of a 256-byte page continues at offset 0 of the same page; the next page is untouched.
- R6: An accepted program or erase sets status bit 0 on chip-select release, holds it for PROG_CYCLES, SECT_CYCLES or BULK_CYCLES clocks (each larger than the walked range plus two), then clears both bit 0 and bit 1.
- R7: While bit 0 is set, only opcode 0x05 is honoured and it returns the status byte once per byte for as long as chip select stays low; other opcodes read back 0x00 on MISO and change nothing.
- R8: Sector erase (0xD8 plus three address bytes) fills the SECTOR_BYTES-aligned range holding the address with 0xFF and leaves other sectors unchanged.
- R9: Bulk erase (0xC7) fills the whole array with 0xFF.
- R10: Read (0x03 plus three address bytes) returns bytes from successive addresses for as long as chip select stays low.
- R11: Signature read (0xAB plus three dummy bytes) returns 0x13 + log2(CHIP_MIB), i.e. 0x13 for a 1 MiB device.
- R12: Status write (0x01 plus one byte) stores bits 7 and 4:2 of that byte, leaves bits 1:0 to the block, and clears the write-enable latch.
- R13: After opcode 0xB9 every opcode except 0xAB is ignored; 0xAB returns the signature and wakes the device on chip-select release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCK rate |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock, idles low |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Serial data into the slave |
| miso | output | 1 | Serial data out of the slave, registered |

## Verification
The hardest case to reach is a command that arrives while a program is still being applied. The master must finish a program, release chip select and start a new frame before the busy counter expires. The stimulus therefore issues a write enable and a read right after a program, well inside PROG_CYCLES. It then checks that the read returned zeros, that the latch did not come back, and that both the programmed byte and the byte that the read targeted hold their correct values once the device is idle.

// File: rtl/nor_emu_pkg.sv
package nor_emu_pkg;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_PROG = 8'h02;
  localparam logic [7:0] OPC_SERS = 8'hD8;
  localparam logic [7:0] OPC_BERS = 8'hC7;
  localparam logic [7:0] OPC_SLEEP = 8'hB9;
  localparam logic [7:0] OPC_SIG = 8'hAB;

  typedef enum logic [1:0] {
    JOB_PROG = 2'd0,
    JOB_SECT = 2'd1,
    JOB_BULK = 2'd2
  } job_e;
endpackage

// File: rtl/nor_emu_spi_if.sv
module nor_emu_spi_if (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       sel,
  output logic       cs_rise,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       tx_load
);
  logic [2:0] sck_q;
  logic [1:0] cs_q;
  logic [1:0] mosi_q;
  logic       cs_d;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic       byte_done;
  logic       sck_rise, sck_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= '0;
      cs_q   <= 2'b11;
      mosi_q <= '0;
      cs_d   <= 1'b1;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      cs_q   <= {cs_q[0], cs_n};
      mosi_q <= {mosi_q[0], mosi};
      cs_d   <= cs_q[1];
    end
  end

  assign sel      = ~cs_q[1];
  assign cs_rise  = cs_q[1] & ~cs_d;
  assign sck_rise = sel & sck_q[1] & ~sck_q[2];
  assign sck_fall = sel & ~sck_q[1] & sck_q[2];

  // receive side: shift on rising SCK
  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      bit_cnt   <= '0;
      rx_sh     <= '0;
      rx_valid  <= 1'b0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (sck_rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_q[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_valid  <= 1'b1;
          rx_byte   <= {rx_sh, mosi_q[1]};
          byte_done <= 1'b1;
        end
      end else if (sck_fall && byte_done) begin
        byte_done <= 1'b0;
      end
    end
  end

  // transmit side: update MISO after falling SCK
  always_ff @(posedge clk) begin
    if (rst || !sel) begin
      tx_sh   <= '0;
      miso    <= 1'b0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (sck_fall) begin
        if (byte_done) begin
          miso    <= tx_byte[7];
          tx_sh   <= {tx_byte[6:0], 1'b0};
          tx_load <= 1'b1;
        end else begin
          miso  <= tx_sh[7];
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/nor_emu_mem.sv
module nor_emu_mem #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nor_emu_engine.sv
module nor_emu_engine
  import nor_emu_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 512,
  parameter int PROG_CYCLES  = 300,
  parameter int SECT_CYCLES  = 600,
  parameter int BULK_CYCLES  = 1100,
  localparam int AW   = $clog2(MEM_BYTES),
  localparam int PW   = $clog2(PAGE_BYTES),
  localparam int MAXC = (PROG_CYCLES > SECT_CYCLES) ?
                        ((PROG_CYCLES > BULK_CYCLES) ? PROG_CYCLES : BULK_CYCLES) :
                        ((SECT_CYCLES > BULK_CYCLES) ? SECT_CYCLES : BULK_CYCLES),
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  job_e          job,
  input  logic [AW-1:0] base,
  input  logic          bclr,
  input  logic          bw_en,
  input  logic [PW-1:0] bw_off,
  input  logic [7:0]    bw_data,
  input  logic [7:0]    mem_rdata,
  output logic [AW-1:0] eng_raddr,
  output logic          eng_we,
  output logic [AW-1:0] eng_waddr,
  output logic [7:0]    eng_wdata,
  output logic          eng_erase_we,
  output logic          busy,
  output logic          done
);
  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pvld;
  logic                  walking;
  logic [AW:0]           idx, last;
  logic [AW-1:0]         base_q;
  job_e                  job_q;
  logic [CW-1:0]         timer;
  logic                  p_vld;
  logic [AW-1:0]         p_addr;
  logic [PW-1:0]         p_off;
  logic [AW:0]           len_m1;
  logic [CW-1:0]         cyc_m1;

  always_comb begin
    unique case (job)
      JOB_PROG: begin len_m1 = (AW+1)'(PAGE_BYTES - 1);   cyc_m1 = CW'(PROG_CYCLES - 1); end
      JOB_SECT: begin len_m1 = (AW+1)'(SECTOR_BYTES - 1); cyc_m1 = CW'(SECT_CYCLES - 1); end
      default:  begin len_m1 = (AW+1)'(MEM_BYTES - 1);    cyc_m1 = CW'(BULK_CYCLES - 1); end
    endcase
  end

  // page staging buffer, AND-merged when a page offset is hit twice
  always_ff @(posedge clk) begin
    if (rst || bclr) begin
      pvld <= '0;
    end else if (bw_en) begin
      pvld[bw_off] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (bw_en && !bclr) pbuf[bw_off] <= pvld[bw_off] ? (pbuf[bw_off] & bw_data) : bw_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      walking <= 1'b0;
      idx     <= '0;
      last    <= '0;
      base_q  <= '0;
      job_q   <= JOB_PROG;
      timer   <= '0;
      p_vld   <= 1'b0;
      p_addr  <= '0;
      p_off   <= '0;
    end else begin
      done   <= 1'b0;
      p_vld  <= walking && (job_q == JOB_PROG);
      p_addr <= eng_raddr;
      p_off  <= idx[PW-1:0];
      if (start && !busy) begin
        busy    <= 1'b1;
        walking <= 1'b1;
        idx     <= '0;
        last    <= len_m1;
        base_q  <= base;
        job_q   <= job;
        timer   <= cyc_m1;
      end else if (busy) begin
        if (walking) begin
          idx <= idx + 1'b1;
          if (idx == last) walking <= 1'b0;
        end
        if (timer != '0) timer <= timer - 1'b1;
        if (!walking && !p_vld && timer == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign eng_raddr    = base_q + idx[AW-1:0];
  assign eng_erase_we = walking && (job_q != JOB_PROG);

  always_comb begin
    if (eng_erase_we) begin
      eng_we    = 1'b1;
      eng_waddr = eng_raddr;
      eng_wdata = 8'hFF;
    end else begin
      eng_we    = p_vld && pvld[p_off];
      eng_waddr = p_addr;
      eng_wdata = mem_rdata & pbuf[p_off];
    end
  end
endmodule

// File: rtl/nor_flash_emu.sv
module nor_flash_emu
  import nor_emu_pkg::*;
#(
  parameter int MEM_BYTES    = 1024,
  parameter int PAGE_BYTES   = 256,
  parameter int SECTOR_BYTES = 512,
  parameter int CHIP_MIB     = 1,
  parameter int PROG_CYCLES  = 300,
  parameter int SECT_CYCLES  = 600,
  parameter int BULK_CYCLES  = 1100
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int SW = $clog2(SECTOR_BYTES);
  localparam logic [7:0] SIG_CODE = 8'h13 + 8'($clog2(CHIP_MIB));

  logic          sel, cs_rise, rx_valid, tx_load;
  logic [7:0]    rx_byte, tx_byte;
  logic [2:0]    idx;
  logic [7:0]    opc;
  logic          cmd_ok, data_seen;
  logic [AW-1:0] addr_q, addr_nxt, rd_addr;
  logic [PW-1:0] pg_off;
  logic [3:0]    wrsr_val;
  logic          wel, srwd, pd;
  logic [2:0]    bp;
  logic          wip, eng_done, eng_start, eng_erase_we;
  job_e          eng_job;
  logic [AW-1:0] eng_base, eng_raddr, eng_waddr;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [7:0]    mem_wdata, mem_rdata;
  logic [7:0]    status;
  logic          streaming;

  nor_emu_spi_if u_spi (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .tx_byte(tx_byte), .miso(miso), .sel(sel), .cs_rise(cs_rise),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_load(tx_load)
  );

  assign status    = {srwd, 2'b00, bp, wel, wip};
  assign addr_nxt  = AW'({addr_q, rx_byte});
  assign streaming = cmd_ok && (opc == OPC_READ) && (idx == 3'd4);

  // opcode acceptance at the first byte
  function automatic logic accept(input logic [7:0] op, input logic asleep, input logic busy_now);
    if (asleep)        return op == OPC_SIG;
    else if (busy_now) return op == OPC_RDSR;
    else               return 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      idx       <= '0;
      opc       <= '0;
      cmd_ok    <= 1'b0;
      data_seen <= 1'b0;
      addr_q    <= '0;
      rd_addr   <= '0;
      pg_off    <= '0;
      wrsr_val  <= '0;
      wel       <= 1'b0;
      srwd      <= 1'b0;
      bp        <= '0;
      pd        <= 1'b0;
    end else begin
      if (rx_valid) begin
        if (idx != 3'd4) idx <= idx + 3'd1;
        if (idx == 3'd0) begin
          opc    <= rx_byte;
          cmd_ok <= accept(rx_byte, pd, wip);
        end else if (idx < 3'd4) begin
          addr_q <= addr_nxt;
          if (idx == 3'd1 && opc == OPC_WRSR) begin
            wrsr_val  <= {rx_byte[7], rx_byte[4:2]};
            data_seen <= 1'b1;
          end
          if (idx == 3'd3) begin
            rd_addr <= addr_nxt;
            pg_off  <= PW'(rx_byte);
          end
        end else if (opc == OPC_PROG) begin
          pg_off    <= pg_off + 1'b1;
          data_seen <= 1'b1;
        end
      end
      if (tx_load && streaming) rd_addr <= rd_addr + 1'b1;
      if (cs_rise && cmd_ok) begin
        unique case (opc)
          OPC_WREN:  wel <= 1'b1;
          OPC_WRDI:  wel <= 1'b0;
          OPC_WRSR:  if (wel && data_seen) begin
                       srwd <= wrsr_val[3];
                       bp   <= wrsr_val[2:0];
                       wel  <= 1'b0;
                     end
          OPC_SLEEP: pd <= 1'b1;
          OPC_SIG:   pd <= 1'b0;
          default:   ;
        endcase
      end
      if (!sel) begin
        idx       <= '0;
        cmd_ok    <= 1'b0;
        data_seen <= 1'b0;
      end
      if (eng_done) wel <= 1'b0;
    end
  end

  // job launch on chip-select release
  always_comb begin
    eng_start = 1'b0;
    eng_job   = JOB_PROG;
    eng_base  = {addr_q[AW-1:PW], PW'(0)};
    if (cs_rise && cmd_ok && wel) begin
      unique case (opc)
        OPC_PROG: eng_start = data_seen;
        OPC_SERS: begin
          eng_start = (idx == 3'd4);
          eng_job   = JOB_SECT;
          eng_base  = {addr_q[AW-1:SW], SW'(0)};
        end
        OPC_BERS: begin
          eng_start = 1'b1;
          eng_job   = JOB_BULK;
          eng_base  = '0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    tx_byte = 8'h00;
    if (cmd_ok) begin
      unique case (opc)
        OPC_RDSR: tx_byte = status;
        OPC_READ: tx_byte = (idx == 3'd4) ? mem_rdata : 8'h00;
        OPC_SIG:  tx_byte = (idx == 3'd4) ? SIG_CODE : 8'h00;
        default:  tx_byte = 8'h00;
      endcase
    end
  end

  nor_emu_engine #(
    .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
    .PROG_CYCLES(PROG_CYCLES), .SECT_CYCLES(SECT_CYCLES), .BULK_CYCLES(BULK_CYCLES)
  ) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .job(eng_job), .base(eng_base),
    .bclr(rx_valid && idx == 3'd0 && !wip && !pd),
    .bw_en(rx_valid && idx == 3'd4 && cmd_ok && opc == OPC_PROG),
    .bw_off(pg_off), .bw_data(rx_byte), .mem_rdata(mem_rdata),
    .eng_raddr(eng_raddr), .eng_we(mem_we), .eng_waddr(eng_waddr),
    .eng_wdata(mem_wdata), .eng_erase_we(eng_erase_we),
    .busy(wip), .done(eng_done)
  );

  assign mem_waddr = eng_waddr;
  assign mem_raddr = wip ? eng_raddr : rd_addr;

  nor_emu_mem #(.DEPTH(MEM_BYTES)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/nor_flash_emu_chk.sv
module nor_flash_emu_chk (
  input logic       clk,
  input logic       rst,
  input logic       wip,
  input logic       wel,
  input logic       mem_we,
  input logic [7:0] mem_wdata,
  input logic       erase_we,
  input logic       cs_rise,
  input logic [3:0] prot
);
  // R6: finishing a job drops the write-enable latch
  p_wel_drop_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |=> !wel);

  // R3: a job only starts with the latch set
  p_start_needs_wel_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> wel);

  // R7: the array changes only inside a busy period
  p_write_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wip);

  // R8: erase writes carry all ones
  p_erase_ones_r8: assert property (@(posedge clk) disable iff (rst)
    erase_we |-> (mem_we && mem_wdata == 8'hFF));

  // R12: protection bits move only at chip-select release
  p_prot_stable_r12: assert property (@(posedge clk) disable iff (rst)
    !cs_rise |=> $stable(prot));
endmodule

bind nor_flash_emu nor_flash_emu_chk u_chk (
  .clk(clk), .rst(rst), .wip(wip), .wel(wel), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .erase_we(eng_erase_we), .cs_rise(cs_rise),
  .prot({srwd, bp})
);

// File: tb/nor_flash_emu_tb.sv
module nor_flash_emu_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  int   n_run = 0;
  int   n_fail = 0;
  logic [7:0] rb [4];
  logic [7:0] st;

  always #2.5 clk = ~clk;

  nor_flash_emu u_dut (.clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  // {address, programmed byte, expected readback}
  localparam logic [39:0] VEC [6] = '{
    40'h000010_A5_A5, 40'h000010_3C_24, 40'h000011_00_00,
    40'h0003FF_7E_7E, 40'h000100_FF_FF, 40'h000010_F0_20
  };

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cs_lo(); wclk(2); cs_n = 1'b0; wclk(6); endtask
  task automatic cs_hi(); wclk(6); cs_n = 1'b1; wclk(10); endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      wclk(6);
      r[i] = miso;
      sck = 1'b1;
      wclk(6);
      sck = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xfer(op, d); cs_hi();
  endtask

  task automatic cmd_addr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] d;
    cs_lo(); xfer(op, d); xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d); cs_hi();
  endtask

  task automatic rd_status(output logic [7:0] s);
    logic [7:0] d;
    cs_lo(); xfer(8'h05, d); xfer(8'h00, s); cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 100; k++) begin
      rd_status(s);
      if (!s[0]) break;
    end
  endtask

  task automatic prog(input logic [23:0] a, input int n, input logic [7:0] d0,
                      input logic [7:0] d1, input logic [7:0] d2);
    logic [7:0] d;
    cs_lo();
    xfer(8'h02, d); xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
    xfer(d0, d);
    if (n > 1) xfer(d1, d);
    if (n > 2) xfer(d2, d);
    cs_hi();
  endtask

  task automatic rd_mem(input logic [23:0] a, input int n);
    logic [7:0] d;
    cs_lo();
    xfer(8'h03, d); xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(8'h00, rb[i]);
    cs_hi();
  endtask

  task automatic wr_status(input logic [7:0] v);
    logic [7:0] d;
    cs_lo(); xfer(8'h01, d); xfer(v, d); cs_hi();
  endtask

  task automatic rd_sig(output logic [7:0] s);
    logic [7:0] d;
    cs_lo();
    xfer(8'hAB, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h00, d); xfer(8'h00, s);
    cs_hi();
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    wclk(10);
    rst = 1'b0;
    wclk(4);

    // R1 reset state
    check("R1 miso low", {7'd0, miso}, 8'h00);
    rd_status(st); check("R1 status", st, 8'h00);

    // R2 latch set and clear
    cmd1(8'h06); rd_status(st); check("R2 wren", st, 8'h02);
    cmd1(8'h04); rd_status(st); check("R2 wrdi", st, 8'h00);

    // R3 program without latch
    prog(24'h000020, 1, 8'h00, 8'h00, 8'h00);
    rd_status(st); check("R3 no busy", st, 8'h00);
    rd_mem(24'h000020, 1); check("R3 prog ignored", rb[0], 8'hFF);

    // R4 table of program/readback pairs
    for (int v = 0; v < 6; v++) begin
      cmd1(8'h06);
      prog(VEC[v][39:16], 1, VEC[v][15:8], 8'h00, 8'h00);
      wait_idle();
      rd_mem(VEC[v][39:16], 1);
      check("R4 and-merge", rb[0], VEC[v][7:0]);
    end

    // R3 erase without latch
    cmd_addr(8'hD8, 24'h000000);
    wait_idle();
    rd_mem(24'h000010, 1); check("R3 erase ignored", rb[0], 8'h20);

    // R6 / R7 busy window and repeated status
    cmd1(8'h06);
    prog(24'h000030, 1, 8'h55, 8'h00, 8'h00);
    cs_lo(); xfer(8'h05, st); xfer(8'h00, rb[0]); xfer(8'h00, rb[1]); cs_hi();
    check("R6 busy set", rb[0], 8'h03);
    check("R7 status repeats", rb[1], 8'h03);
    wait_idle();
    rd_status(st); check("R6 idle clears", st, 8'h00);
    rd_mem(24'h000030, 1); check("R6 prog done", rb[0], 8'h55);

    // R7 commands ignored while busy
    cmd1(8'h06);
    prog(24'h000040, 1, 8'h11, 8'h00, 8'h00);
    cmd1(8'h06);
    rd_mem(24'h000010, 1); check("R7 read ignored", rb[0], 8'h00);
    wait_idle();
    rd_status(st); check("R7 wren ignored", st, 8'h00);
    rd_mem(24'h000040, 1); check("R7 prog kept", rb[0], 8'h11);
    rd_mem(24'h000010, 1); check("R7 data kept", rb[0], 8'h20);

    // R5 page wrap
    cmd1(8'h06);
    prog(24'h0002FE, 3, 8'h11, 8'h22, 8'h33);
    wait_idle();
    rd_mem(24'h000200, 1); check("R5 wrap to page start", rb[0], 8'h33);
    rd_mem(24'h000300, 1); check("R5 next page untouched", rb[0], 8'hFF);

    // R10 streaming read across page end
    rd_mem(24'h0002FE, 3);
    check("R10 byte0", rb[0], 8'h11);
    check("R10 byte1", rb[1], 8'h22);
    check("R10 byte2", rb[2], 8'hFF);

    // R8 sector erase
    cmd1(8'h06);
    cmd_addr(8'hD8, 24'h0000AB);
    wait_idle();
    rd_mem(24'h000010, 1); check("R8 erased", rb[0], 8'hFF);
    rd_mem(24'h000040, 1); check("R8 erased hi", rb[0], 8'hFF);
    rd_mem(24'h000200, 1); check("R8 other sector", rb[0], 8'h33);
    rd_mem(24'h0003FF, 1); check("R8 other sector end", rb[0], 8'h7E);

    // R11 signature
    rd_sig(st); check("R11 signature", st, 8'h13);

    // R9 bulk erase
    cmd1(8'h06);
    cmd1(8'hC7);
    wait_idle();
    rd_mem(24'h000200, 1); check("R9 bulk", rb[0], 8'hFF);
    rd_mem(24'h0003FF, 1); check("R9 bulk end", rb[0], 8'hFF);

    // R12 status write
    wr_status(8'h9C);
    rd_status(st); check("R12 no latch ignored", st, 8'h00);
    cmd1(8'h06);
    wr_status(8'h9F);
    rd_status(st); check("R12 stored bits", st, 8'h9C);

    // R13 deep sleep
    cmd1(8'hB9);
    rd_status(st); check("R13 status ignored", st, 8'h00);
    cmd1(8'h06);
    rd_sig(st); check("R13 signature wakes", st, 8'h13);
    rd_status(st); check("R13 awake, wren ignored", st, 8'h9C);

    finish_run();
  end
endmodule